// File: doc/BRIEF.md
# Command-Driven Read Scrambler with Low Page Overlay

This block sits on a cartridge bus and answers reads from a dedicated device window with a byte derived from a stored operand. Software first stores an operand byte and an operation code through byte writes into the lower half of the window. Every later read anywhere in the window returns the operand after the selected transform: a right shift by one, an exchange of the two nibbles, or a full reversal of the bit order. Any unknown operation code yields zero.

Writes into the upper half of the window choose a 32 KB page of ROM. The block translates every CPU address in the lowest 32 KB into an address inside that page. It does this by swapping in the page number above the 15-bit offset. All other addresses reach ROM unchanged. A page selection whose last byte would fall beyond the ROM size is dropped, and the previous selection stays. Page zero maps the low window onto itself. ROM storage is outside the block.

Top module: `prot_scrambler`

## Requirements
- R1: After reset the operation code, operand and page are zero: window reads return 0x00 and low addresses translate to themselves.
- R2: A write strobe with the address in 0x600000..0x6FFFFF loads the operation code when address bit 1 is 1. When address bit 1 is 0, it loads the operand instead.
- R3: With operation code 0x01, a window read returns the operand shifted right by one, with zero entering bit 7.
- R4: With operation code 0x02, a window read returns the operand with bits 7..4 and bits 3..0 exchanged.
- R5: With operation code 0x03, a window read returns the operand with bit i moved to bit 7-i.
- R6: With any operation code other than 0x01, 0x02 or 0x03, a window read returns 0x00.
- R7: A read strobe with the address in 0x600000..0x7FFFFF raises rd_hit and drives the transform result. Otherwise rd_hit is 0 and rd_data is 0x00.
- R8: A write strobe with the address in 0x700000..0x7FFFFF stores the write data as the page number. From the next cycle on, an address A below 0x8000 translates to page*0x8000 + A.
- R9: Page 0 translates the low 32 KB onto itself.
- R10: A page write is ignored when (page+1)*0x8000 exceeds ROM_BYTES (default 0x200000, so pages 0..63 are accepted). The earlier translation stays in force.
- R11: Any address at or above 0x8000 appears on rom_addr unchanged, whatever the page.
- R12: Writes outside 0x600000..0x7FFFFF change neither the operation code, the operand nor the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 24 | CPU byte address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_wr | input | 1 | Write strobe, one cycle per byte written |
| cpu_rd | input | 1 | Read strobe |
| rd_hit | output | 1 | Read falls inside the device window |
| rd_data | output | 8 | Transformed read byte, zero when rd_hit is low |
| rom_addr | output | 24 | Translated ROM address |

## Verification
The hardest case to reach is an oversized page write that arrives while a nonzero page is already in force. The bench has to show that the old translation survives, not merely that the register is still zero. The random stimulus draws page values across a range that runs past the ROM limit. It interleaves them with accepted page writes, so rejected writes land on many different live pages. Operation codes are drawn to hit 0..3 often, and also take arbitrary values, so unknown codes appear after valid ones. Directed steps cover page 63 against page 64, page 0, and a stray write just outside the window.

// File: rtl/prot_scrambler_pkg.sv
package prot_scrambler_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [BYTE_W-1:0] {
        OP_NONE  = 8'h00,
        OP_SHIFT = 8'h01,
        OP_SWAP  = 8'h02,
        OP_REV   = 8'h03
    } op_e;

    typedef struct packed {
        logic [BYTE_W-1:0] op;
        logic [BYTE_W-1:0] operand;
        logic [BYTE_W-1:0] page;
    } scr_state_t;
endpackage

// File: rtl/prot_decode.sv
module prot_decode #(
    parameter int                ADDR_W     = 24,
    parameter logic [ADDR_W-1:0] DEV_BASE   = 24'h600000,
    parameter int                HALF_LOG2  = 20,
    parameter int                PAGE_SHIFT = 15
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_dev,
    output logic              in_ctl,
    output logic              in_page,
    output logic              in_low
);
    localparam int TAG_LO = HALF_LOG2 + 1;

    always_comb begin
        in_dev  = (addr[ADDR_W-1:TAG_LO] == DEV_BASE[ADDR_W-1:TAG_LO]);
        in_ctl  = in_dev && !addr[HALF_LOG2];
        in_page = in_dev &&  addr[HALF_LOG2];
        in_low  = (addr[ADDR_W-1:PAGE_SHIFT] == '0);
    end
endmodule

// File: rtl/prot_xform.sv
module prot_xform
    import prot_scrambler_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic [W-1:0] op,
    input  logic [W-1:0] operand,
    output logic [W-1:0] result
);
    localparam int HALF = W / 2;

    logic [W-1:0] rev;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev[i] = operand[W-1-i];
    end

    always_comb begin
        unique case (op)
            OP_SHIFT: result = operand >> 1;
            OP_SWAP:  result = {operand[HALF-1:0], operand[W-1:HALF]};
            OP_REV:   result = rev;
            default:  result = '0;
        endcase
    end
endmodule

// File: rtl/prot_remap.sv
module prot_remap #(
    parameter int ADDR_W     = 24,
    parameter int PAGE_W     = 8,
    parameter int PAGE_SHIFT = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              in_low,
    input  logic [PAGE_W-1:0] page,
    output logic [ADDR_W-1:0] rom_addr
);
    logic [ADDR_W-1:0] page_base;

    always_comb begin
        page_base = ADDR_W'(page) << PAGE_SHIFT;
        rom_addr  = in_low ? (page_base | ADDR_W'(addr[PAGE_SHIFT-1:0])) : addr;
    end
endmodule

// File: rtl/prot_scrambler.sv
module prot_scrambler
    import prot_scrambler_pkg::*;
#(
    parameter int                ADDR_W     = 24,
    parameter logic [ADDR_W-1:0] DEV_BASE   = 24'h600000,
    parameter int                HALF_LOG2  = 20,
    parameter int                PAGE_SHIFT = 15,
    parameter int unsigned       ROM_BYTES  = 32'h0020_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic              rd_hit,
    output logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rom_addr
);
    localparam int              END_W     = ADDR_W + 1;
    localparam logic [END_W-1:0] ROM_LIMIT = END_W'(ROM_BYTES);

    scr_state_t state_d, state_q;

    logic              in_dev, in_ctl, in_page, in_low;
    logic [BYTE_W-1:0] xf_result;
    logic [END_W-1:0]  page_end;
    logic              page_fits;

    prot_decode #(
        .ADDR_W    (ADDR_W),
        .DEV_BASE  (DEV_BASE),
        .HALF_LOG2 (HALF_LOG2),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) u_decode (
        .addr   (cpu_addr),
        .in_dev (in_dev),
        .in_ctl (in_ctl),
        .in_page(in_page),
        .in_low (in_low)
    );

    prot_xform #(.W(BYTE_W)) u_xform (
        .op     (state_q.op),
        .operand(state_q.operand),
        .result (xf_result)
    );

    prot_remap #(
        .ADDR_W    (ADDR_W),
        .PAGE_W    (BYTE_W),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) u_remap (
        .addr    (cpu_addr),
        .in_low  (in_low),
        .page    (state_q.page),
        .rom_addr(rom_addr)
    );

    always_comb begin
        page_end  = (END_W'(cpu_wdata) + END_W'(1)) << PAGE_SHIFT;
        page_fits = (page_end <= ROM_LIMIT);

        state_d = state_q;
        if (cpu_wr) begin
            if (in_ctl) begin
                if (cpu_addr[1]) state_d.op      = cpu_wdata;
                else             state_d.operand = cpu_wdata;
            end
            if (in_page && page_fits) begin
                state_d.page = cpu_wdata;
            end
        end

        rd_hit  = cpu_rd && in_dev;
        rd_data = rd_hit ? xf_result : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/prot_scrambler_chk.sv
module prot_scrambler_chk #(
    parameter int          ADDR_W     = 24,
    parameter int          PAGE_SHIFT = 15,
    parameter int unsigned ROM_BYTES  = 32'h0020_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_wr,
    input logic              rd_hit,
    input logic [7:0]        rd_data,
    input logic [7:0]        op_q,
    input logic [7:0]        operand_q,
    input logic [7:0]        page_q
);
    logic ctl_win, page_win, any_win, too_big;

    always_comb begin
        ctl_win  = (cpu_addr[ADDR_W-1:20] == 4'h6);
        page_win = (cpu_addr[ADDR_W-1:20] == 4'h7);
        any_win  = ctl_win || page_win;
        too_big  = ((33'(cpu_wdata) + 33'd1) << PAGE_SHIFT) > 33'(ROM_BYTES);
    end

    assert_op_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && ctl_win && cpu_addr[1] |=> op_q == $past(cpu_wdata));

    assert_operand_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && ctl_win && !cpu_addr[1] |=> operand_q == $past(cpu_wdata));

    assert_shift_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit && op_q == 8'h01 |-> !rd_data[7]);

    assert_swap_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit && op_q == 8'h02 |-> $countones(rd_data) == $countones(operand_q));

    assert_rev_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit && op_q == 8'h03 |-> $countones(rd_data) == $countones(operand_q));

    assert_unknown_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit && (op_q == 8'h00 || op_q > 8'h03) |-> rd_data == 8'h00);

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> rd_data == 8'h00);

    assert_oversize_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && page_win && too_big |=> $stable(page_q));

    assert_outside_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && !any_win |=> $stable(op_q) && $stable(operand_q) && $stable(page_q));
endmodule

bind prot_scrambler prot_scrambler_chk #(
    .ADDR_W    (ADDR_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .ROM_BYTES (ROM_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .cpu_wr   (cpu_wr),
    .rd_hit   (rd_hit),
    .rd_data  (rd_data),
    .op_q     (state_q.op),
    .operand_q(state_q.operand),
    .page_q   (state_q.page)
);

// File: tb/prot_scrambler_bench.sv
module prot_scrambler_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic        rd_hit;
    logic [7:0]  rd_data;
    logic [23:0] rom_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_op = '0, m_operand = '0, m_page = '0;

    always #4 clk = ~clk;

    prot_scrambler u_prot_scrambler (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rd_hit(rd_hit), .rd_data(rd_data),
        .rom_addr(rom_addr)
    );

    function automatic logic [7:0] exp_xf(logic [7:0] op, logic [7:0] d);
        logic [7:0] r;
        r = 8'h00;
        if (op == 8'h01) r = {1'b0, d[7:1]};
        else if (op == 8'h02) r = {d[3:0], d[7:4]};
        else if (op == 8'h03) for (int i = 0; i < 8; i++) r[i] = d[7-i];
        return r;
    endfunction

    function automatic logic [23:0] exp_rom(logic [23:0] a, logic [7:0] pg);
        if (a < 24'h8000) return {1'b0, pg, a[14:0]};
        return a;
    endfunction

    task automatic check(string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [23:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
        if (a[23:20] == 4'h6) begin
            if (a[1]) m_op = d; else m_operand = d;
        end else if (a[23:20] == 4'h7) begin
            if ((32'(d) + 1) * 32'h8000 <= 32'h200000) m_page = d;
        end
    endtask

    task automatic rd_check(string req, logic [23:0] a);
        logic hit;
        cpu_addr = a; cpu_rd = 1'b1;
        #1;
        hit = (a[23:20] == 4'h6) || (a[23:20] == 4'h7);
        check(req, {23'd0, rd_hit}, {23'd0, hit});
        check(req, {16'd0, rd_data}, {16'd0, hit ? exp_xf(m_op, m_operand) : 8'h00});
        cpu_rd = 1'b0;
    endtask

    task automatic map_check(string req, logic [23:0] a);
        cpu_addr = a;
        #1;
        check(req, rom_addr, exp_rom(a, m_page));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_check("R1", 24'h600000);
        map_check("R1", 24'h001234);

        // R2 loads, R3..R6 transforms
        wr(24'h600000, 8'hB4);
        wr(24'h600002, 8'h01);
        @(negedge clk); rd_check("R3", 24'h600001);
        wr(24'h600002, 8'h02);
        @(negedge clk); rd_check("R4", 24'h7FFFFF);
        wr(24'h600002, 8'h03);
        @(negedge clk); rd_check("R5", 24'h6ABCD1);
        wr(24'h600002, 8'h04);
        @(negedge clk); rd_check("R6", 24'h600000);
        wr(24'h600002, 8'h03);
        wr(24'h600001, 8'h81);
        @(negedge clk); rd_check("R2", 24'h700000);
        // R7 outside window
        rd_check("R7", 24'h5FFFFF);
        rd_check("R7", 24'h800000);

        // R8/R10 page boundary
        wr(24'h700000, 8'd63);
        @(negedge clk); map_check("R8", 24'h007FFF);
        wr(24'h712345, 8'd64);
        @(negedge clk); map_check("R10", 24'h000010);
        wr(24'h700001, 8'd5);
        wr(24'h7FFFFF, 8'd255);
        @(negedge clk); map_check("R10", 24'h004000);
        map_check("R11", 24'h008000);
        map_check("R11", 24'h7FFFFF);
        wr(24'h700000, 8'd0);
        @(negedge clk); map_check("R9", 24'h005555);

        // R12 stray writes
        wr(24'h700000, 8'd9);
        wr(24'h800002, 8'h55);
        wr(24'h5FFFFE, 8'h01);
        wr(24'h000000, 8'd2);
        @(negedge clk);
        rd_check("R12", 24'h600000);
        map_check("R12", 24'h000100);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int unsigned k;
            logic [23:0] a;
            k = $urandom_range(0, 5);
            a = {$urandom()} & 24'hFFFFFF;
            case (k)
                0: wr({4'h6, a[19:2], 1'b1, a[0]}, ($urandom_range(0, 3) == 0) ? 8'($urandom()) : 8'($urandom_range(0, 3)));
                1: wr({4'h6, a[19:2], 1'b0, a[0]}, 8'($urandom()));
                2: wr({4'h7, a[19:0]}, 8'($urandom_range(0, 90)));
                3: wr(($urandom_range(0, 1) == 0) ? {4'h5, a[19:0]} : {4'h9, a[19:0]}, 8'($urandom()));
                default: @(negedge clk);
            endcase
            @(negedge clk);
            rd_check("R7", {3'b011, a[20:0]});
            map_check("R8", {9'd0, a[14:0]});
            map_check("R11", a | 24'h008000);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule